// File: doc/BRIEF.md
# Instruction Breakpoint Match Unit

This unit holds a bank of sixteen hardware breakpoints for a processor debug block. Each breakpoint has a 64-bit control register and a 64-bit value register, both loaded through a single register write port and read back through a combinational read port. Every cycle the unit may be given one retiring instruction: its address, the current context identifier and the current virtual machine identifier. One cycle later it reports which breakpoints matched as a 16-bit hit vector, together with a single event flag.

A breakpoint is one of two kinds. An address breakpoint compares the instruction address with the value register and then selects half-words through a 4-bit select field. A context breakpoint compares the context ID, the VMID or both. An address breakpoint can be chained through a 4-bit link index to a linkable context breakpoint, so that it reports only inside one particular context. Security-state and privilege fields are stored but place no limit on matching.

Top module: `bpm_match_unit`

## Requirements
- R1: Control bit 0 enables a breakpoint. While it is clear, that breakpoint never sets its hit bit, whatever its link index holds.
- R2: Control type code 0000 (bits [23:20]) is an unlinked address match. Value bits [63:2] must equal instruction address bits [63:2], and then the select field in bits [8:5] is applied: 1111 accepts either half-word, 0011 accepts only address bit 1 = 0, and 1100 accepts only address bit 1 = 1.
- R3: An address breakpoint whose select field holds any other value never hits.
- R4: Type codes 0010 and 0110 compare value bits [31:0] with the context ID. Code 1000 compares value bits [47:32] with the VMID. Code 1010 requires both to match. The select field has no effect on these codes.
- R5: The linkable context codes 0011, 0111, 1001 and 1011 never set their own hit bit.
- R6: Type code 0001 hits only when its address match (R2) holds and the breakpoint named by control bits [19:16] is enabled, carries a linkable context code, and matches the current context.
- R7: A linked address breakpoint whose link index names a breakpoint that is disabled, is not a context code, or is a non-linkable context code never hits.
- R8: Type codes 0100, 0101, 1100, 1101, 1110 and 1111 never hit.
- R9: Control bits [63:24], [12:9] and [4:3] read as zero and ignore writes. All other control bits, and all 64 value bits, read back as written.
- R10: The hit vector and the event flag change on the clock edge after the edge that samples a valid instruction. In the cycle after an edge with no valid instruction, both are zero. The event flag is set exactly when the hit vector is nonzero.
- R11: After reset every register reads zero and both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 control, 1 value |
| wrIdx | input | 4 | Breakpoint index being written |
| wrData | input | 64 | Write data |
| rdSel | input | 1 | Read target: 0 control, 1 value |
| rdIdx | input | 4 | Breakpoint index being read |
| rdData | output | 64 | Combinational read data |
| instValid | input | 1 | A retiring instruction is present |
| instAddr | input | 64 | Address of that instruction |
| curCtxId | input | 32 | Current context identifier |
| curVmid | input | 16 | Current virtual machine identifier |
| hitVec | output | 16 | Registered per-breakpoint hit vector |
| bpEvent | output | 1 | Registered OR of the hit vector |

## Verification
Address matching is driven with addresses at the programmed word, at its upper half-word and at the next word, so that the three legal select patterns can be told apart from an illegal one. Context matching is driven with the right and wrong context ID and VMID separately, which separates the single-field codes from the code that needs both. Linking is tried with a good target and then with targets that are non-linkable, disabled or address-type. In each case a silent linked breakpoint must be seen next to a hitting unlinked one, so that a wrong target lookup shows up in the vector. Gaps in the valid input and several simultaneous hits confirm the one-cycle timing and the event flag.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  localparam int BPM_NUM   = 16;
  localparam int BPM_IDX_W = $clog2(BPM_NUM);
  localparam int REG_W     = 64;

  // Field positions in the control word
  localparam int TYPE_LSB  = 20;
  localparam int LINK_LSB  = 16;
  localparam int SEL_LSB   = 5;
  localparam logic [REG_W-1:0] CTRL_KEEP_MASK = 64'h0000_0000_00FF_E1E7;

  typedef enum logic [3:0] {
    BT_ADDR      = 4'b0000,
    BT_ADDR_LNK  = 4'b0001,
    BT_CID       = 4'b0010,
    BT_CID_LNK   = 4'b0011,
    BT_CIDB      = 4'b0110,
    BT_CIDB_LNK  = 4'b0111,
    BT_VM        = 4'b1000,
    BT_VM_LNK    = 4'b1001,
    BT_VMCID     = 4'b1010,
    BT_VMCID_LNK = 4'b1011
  } bpType_e;

  typedef struct packed {
    logic                 ctrlWe;
    logic                 valueWe;
    logic [BPM_IDX_W-1:0] wrIdx;
    logic [REG_W-1:0]     wrData;
    logic                 sample;
  } bpmStrobe_t;

  function automatic logic isCtxType(input logic [3:0] bt);
    case (bt)
      BT_CID, BT_CID_LNK, BT_CIDB, BT_CIDB_LNK,
      BT_VM, BT_VM_LNK, BT_VMCID, BT_VMCID_LNK: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic needsCid(input logic [3:0] bt);
    case (bt)
      BT_CID, BT_CID_LNK, BT_CIDB, BT_CIDB_LNK, BT_VMCID, BT_VMCID_LNK: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic needsVm(input logic [3:0] bt);
    return bt[3] && !bt[2];
  endfunction

  function automatic logic selAccepts(input logic [3:0] sel, input logic addrBit1);
    case (sel)
      4'b1111: return 1'b1;
      4'b0011: return !addrBit1;
      4'b1100: return addrBit1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bpm_ctrl.sv
module bpm_ctrl
  import bpm_pkg::*;
(
  input  logic                 wrEn,
  input  logic                 wrSel,
  input  logic [BPM_IDX_W-1:0] wrIdx,
  input  logic [REG_W-1:0]     wrData,
  input  logic                 instValid,
  output bpmStrobe_t           strobe
);
  always_comb begin
    strobe.ctrlWe  = wrEn && !wrSel;
    strobe.valueWe = wrEn && wrSel;
    strobe.wrIdx   = wrIdx;
    strobe.wrData  = wrSel ? wrData : (wrData & CTRL_KEEP_MASK);
    strobe.sample  = instValid;
  end
endmodule

// File: rtl/bpm_datapath.sv
module bpm_datapath
  import bpm_pkg::*;
#(
  parameter int NUM_BP   = BPM_NUM,
  parameter int CTX_W    = 32,
  parameter int VMID_W   = 16,
  parameter int VMID_LSB = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  bpmStrobe_t           strobe,
  input  logic [REG_W-1:0]     instAddr,
  input  logic [CTX_W-1:0]     curCtxId,
  input  logic [VMID_W-1:0]    curVmid,
  input  logic                 rdSel,
  input  logic [BPM_IDX_W-1:0] rdIdx,
  output logic [REG_W-1:0]     rdData,
  output logic [NUM_BP-1:0]    hitVec,
  output logic                 bpEvent,
  output logic [NUM_BP-1:0]    enVec,
  output logic [NUM_BP-1:0]    linkableVec
);
  logic [REG_W-1:0]  ctrlReg  [NUM_BP];
  logic [REG_W-1:0]  valueReg [NUM_BP];
  logic [NUM_BP-1:0] ctxOk;
  logic [NUM_BP-1:0] linkTgt;
  logic [NUM_BP-1:0] hitNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_BP; k++) begin
        ctrlReg[k]  <= '0;
        valueReg[k] <= '0;
      end
    end else begin
      if (strobe.ctrlWe)  ctrlReg[strobe.wrIdx]  <= strobe.wrData;
      if (strobe.valueWe) valueReg[strobe.wrIdx] <= strobe.wrData;
    end
  end

  assign rdData = rdSel ? valueReg[rdIdx] : ctrlReg[rdIdx];

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    logic [3:0]           bt;
    logic [3:0]           sel;
    logic [BPM_IDX_W-1:0] lnk;
    logic                 en;
    logic                 cidEq;
    logic                 vmEq;
    logic                 addrOk;

    assign bt    = ctrlReg[i][TYPE_LSB +: 4];
    assign sel   = ctrlReg[i][SEL_LSB +: 4];
    assign lnk   = ctrlReg[i][LINK_LSB +: BPM_IDX_W];
    assign en    = ctrlReg[i][0];
    assign cidEq = valueReg[i][CTX_W-1:0] == curCtxId;
    assign vmEq  = valueReg[i][VMID_LSB +: VMID_W] == curVmid;

    assign ctxOk[i] = en && isCtxType(bt) && (!needsCid(bt) || cidEq) && (!needsVm(bt) || vmEq);
    assign linkTgt[i] = ctxOk[i] && bt[0];
    assign addrOk = en && (bt[3:1] == 3'b000)
                    && (valueReg[i][REG_W-1:2] == instAddr[REG_W-1:2])
                    && selAccepts(sel, instAddr[1]);

    always_comb begin
      if (bt == BT_ADDR)          hitNext[i] = addrOk;
      else if (bt == BT_ADDR_LNK) hitNext[i] = addrOk && linkTgt[lnk];
      else                        hitNext[i] = ctxOk[i] && !bt[0];
    end

    assign enVec[i]       = en;
    assign linkableVec[i] = isCtxType(bt) && bt[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hitVec  <= '0;
      bpEvent <= 1'b0;
    end else begin
      hitVec  <= strobe.sample ? hitNext : '0;
      bpEvent <= strobe.sample && (hitNext != '0);
    end
  end
endmodule

// File: rtl/bpm_match_unit.sv
module bpm_match_unit
  import bpm_pkg::*;
#(
  parameter int NUM_BP   = BPM_NUM,
  parameter int CTX_W    = 32,
  parameter int VMID_W   = 16,
  parameter int VMID_LSB = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrEn,
  input  logic                 wrSel,
  input  logic [BPM_IDX_W-1:0] wrIdx,
  input  logic [REG_W-1:0]     wrData,
  input  logic                 rdSel,
  input  logic [BPM_IDX_W-1:0] rdIdx,
  output logic [REG_W-1:0]     rdData,
  input  logic                 instValid,
  input  logic [REG_W-1:0]     instAddr,
  input  logic [CTX_W-1:0]     curCtxId,
  input  logic [VMID_W-1:0]    curVmid,
  output logic [NUM_BP-1:0]    hitVec,
  output logic                 bpEvent
);
  bpmStrobe_t        strobe;
  logic [NUM_BP-1:0] enVec;
  logic [NUM_BP-1:0] linkableVec;

  bpm_ctrl u_ctrl (
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .wrIdx     (wrIdx),
    .wrData    (wrData),
    .instValid (instValid),
    .strobe    (strobe)
  );

  bpm_datapath #(
    .NUM_BP   (NUM_BP),
    .CTX_W    (CTX_W),
    .VMID_W   (VMID_W),
    .VMID_LSB (VMID_LSB)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .instAddr    (instAddr),
    .curCtxId    (curCtxId),
    .curVmid     (curVmid),
    .rdSel       (rdSel),
    .rdIdx       (rdIdx),
    .rdData      (rdData),
    .hitVec      (hitVec),
    .bpEvent     (bpEvent),
    .enVec       (enVec),
    .linkableVec (linkableVec)
  );
endmodule

// File: rtl/bpm_checker.sv
module bpm_checker
  import bpm_pkg::*;
#(
  parameter int NUM_BP = BPM_NUM
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instValid,
  input logic [NUM_BP-1:0] hitVec,
  input logic              bpEvent,
  input logic [NUM_BP-1:0] enVec,
  input logic [NUM_BP-1:0] linkableVec,
  input logic              rdSel,
  input logic [REG_W-1:0]  rdData
);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(instValid) |-> (hitVec == '0 && !bpEvent));

  assert_event_agrees_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bpEvent == (hitVec != '0));

  assert_disabled_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hitVec & ~$past(enVec)) == '0);

  assert_linkable_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hitVec & $past(linkableVec)) == '0);

  assert_ctrl_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rdSel |-> ((rdData & ~CTRL_KEEP_MASK) == '0));
endmodule

bind bpm_match_unit bpm_checker #(.NUM_BP(NUM_BP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instValid   (instValid),
  .hitVec      (hitVec),
  .bpEvent     (bpEvent),
  .enVec       (enVec),
  .linkableVec (linkableVec),
  .rdSel       (rdSel),
  .rdData      (rdData)
);

// File: tb/bpm_match_unit_tb.sv
module bpm_match_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [3:0]  wrIdx = '0;
  logic [63:0] wrData = '0;
  logic        rdSel = 1'b0;
  logic [3:0]  rdIdx = '0;
  logic [63:0] rdData;
  logic        instValid = 1'b0;
  logic [63:0] instAddr = '0;
  logic [31:0] curCtxId = '0;
  logic [15:0] curVmid = '0;
  logic [15:0] hitVec;
  logic        bpEvent;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bpm_match_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx),
    .wrData(wrData), .rdSel(rdSel), .rdIdx(rdIdx), .rdData(rdData),
    .instValid(instValid), .instAddr(instAddr), .curCtxId(curCtxId),
    .curVmid(curVmid), .hitVec(hitVec), .bpEvent(bpEvent)
  );

  function automatic logic [63:0] mkCtrl(input logic [3:0] bt, input logic [3:0] lnk,
                                         input logic [3:0] sel, input logic en);
    return {40'd0, bt, lnk, 2'b00, 1'b0, 4'b0000, sel, 2'b00, 2'b00, en};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic sel, input logic [3:0] idx, input logic [63:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrIdx = idx; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic clearAll();
    for (int k = 0; k < 16; k++) wrReg(1'b0, 4'(k), 64'd0);
  endtask

  // Present one instruction, then check the registered result one edge later.
  task automatic runInst(input string req, input logic [63:0] a, input logic [31:0] cid,
                         input logic [15:0] vm, input logic [15:0] expHit);
    @(negedge clk);
    instValid = 1'b1; instAddr = a; curCtxId = cid; curVmid = vm;
    @(negedge clk);
    instValid = 1'b0;
    check(req, {48'd0, hitVec}, {48'd0, expHit});
    check(req, {63'd0, bpEvent}, {63'd0, expHit != 16'd0});
  endtask

  task automatic tReset();
    check("R11 hit", {48'd0, hitVec}, 64'd0);
    check("R11 event", {63'd0, bpEvent}, 64'd0);
    rdSel = 1'b0; rdIdx = 4'd3; #1;
    check("R11 ctrl", rdData, 64'd0);
    rdSel = 1'b1; #1;
    check("R11 value", rdData, 64'd0);
  endtask

  task automatic tReserved();
    wrReg(1'b0, 4'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    rdSel = 1'b0; rdIdx = 4'd2; #1;
    check("R9 ctrl mask", rdData, 64'h0000_0000_00FF_E1E7);
    wrReg(1'b1, 4'd2, 64'hDEAD_BEEF_0123_4567);
    rdSel = 1'b1; #1;
    check("R9 value", rdData, 64'hDEAD_BEEF_0123_4567);
    wrReg(1'b0, 4'd2, 64'd0);
  endtask

  task automatic tAddr();
    clearAll();
    wrReg(1'b1, 4'd0, 64'h1000); wrReg(1'b0, 4'd0, mkCtrl(4'b0000, 4'd0, 4'b1111, 1'b1));
    wrReg(1'b1, 4'd1, 64'h2000); wrReg(1'b0, 4'd1, mkCtrl(4'b0000, 4'd0, 4'b0011, 1'b1));
    wrReg(1'b1, 4'd3, 64'h3000); wrReg(1'b0, 4'd3, mkCtrl(4'b0000, 4'd0, 4'b1100, 1'b1));
    runInst("R2 full low", 64'h1000, 0, 0, 16'h0001);
    runInst("R2 full high", 64'h1002, 0, 0, 16'h0001);
    runInst("R2 next word", 64'h1004, 0, 0, 16'h0000);
    runInst("R2 lo sel lo", 64'h2000, 0, 0, 16'h0002);
    runInst("R2 lo sel hi", 64'h2002, 0, 0, 16'h0000);
    runInst("R2 hi sel hi", 64'h3002, 0, 0, 16'h0008);
    runInst("R2 hi sel lo", 64'h3000, 0, 0, 16'h0000);
    wrReg(1'b1, 4'd4, 64'h4000); wrReg(1'b0, 4'd4, mkCtrl(4'b0000, 4'd0, 4'b0101, 1'b1));
    runInst("R3 bad select", 64'h4000, 0, 0, 16'h0000);
    wrReg(1'b0, 4'd0, mkCtrl(4'b0000, 4'd0, 4'b1111, 1'b0));
    runInst("R1 disabled", 64'h1000, 0, 0, 16'h0000);
  endtask

  task automatic tTiming();
    clearAll();
    wrReg(1'b1, 4'd0, 64'h5000); wrReg(1'b0, 4'd0, mkCtrl(4'b0000, 4'd0, 4'b1111, 1'b1));
    wrReg(1'b1, 4'd15, 64'h5000); wrReg(1'b0, 4'd15, mkCtrl(4'b0000, 4'd0, 4'b1111, 1'b1));
    @(negedge clk);
    instAddr = 64'h5000; instValid = 1'b0;
    @(negedge clk);
    check("R10 no valid", {48'd0, hitVec}, 64'd0);
    runInst("R10 two hits", 64'h5000, 0, 0, 16'h8001);
    @(negedge clk);
    check("R10 drops after", {48'd0, hitVec}, 64'd0);
    check("R10 event drops", {63'd0, bpEvent}, 64'd0);
  endtask

  task automatic tContext();
    clearAll();
    wrReg(1'b1, 4'd5, 64'h0000_0000_0000_ABCD); wrReg(1'b0, 4'd5, mkCtrl(4'b0010, 4'd0, 4'b0000, 1'b1));
    wrReg(1'b1, 4'd6, 64'h0000_0055_0000_0000); wrReg(1'b0, 4'd6, mkCtrl(4'b1000, 4'd0, 4'b0101, 1'b1));
    wrReg(1'b1, 4'd7, 64'h0000_0066_0000_1234); wrReg(1'b0, 4'd7, mkCtrl(4'b1010, 4'd0, 4'b0000, 1'b1));
    wrReg(1'b1, 4'd9, 64'h0000_0000_0000_4321); wrReg(1'b0, 4'd9, mkCtrl(4'b0110, 4'd0, 4'b0000, 1'b1));
    runInst("R4 cid match", 0, 32'hABCD, 16'h0, 16'h0020);
    runInst("R4 cid miss", 0, 32'hABCE, 16'h0, 16'h0000);
    runInst("R4 vmid match", 0, 32'h0, 16'h0055, 16'h0040);
    runInst("R4 both match", 0, 32'h1234, 16'h0066, 16'h0080);
    runInst("R4 both vm miss", 0, 32'h1234, 16'h0067, 16'h0000);
    runInst("R4 alt cid", 0, 32'h4321, 16'h0, 16'h0200);
  endtask

  task automatic tLink();
    clearAll();
    wrReg(1'b1, 4'd8, 64'h77); wrReg(1'b0, 4'd8, mkCtrl(4'b0011, 4'd0, 4'b0000, 1'b1));
    wrReg(1'b1, 4'd9, 64'h9000); wrReg(1'b0, 4'd9, mkCtrl(4'b0001, 4'd8, 4'b1111, 1'b1));
    runInst("R5 linkable alone", 64'h0, 32'h77, 0, 16'h0000);
    runInst("R6 linked hit", 64'h9000, 32'h77, 0, 16'h0200);
    runInst("R6 linked ctx miss", 64'h9000, 32'h78, 0, 16'h0000);
    wrReg(1'b1, 4'd11, 64'h88); wrReg(1'b0, 4'd11, mkCtrl(4'b0010, 4'd0, 4'b0000, 1'b1));
    wrReg(1'b1, 4'd10, 64'hA000); wrReg(1'b0, 4'd10, mkCtrl(4'b0001, 4'd11, 4'b1111, 1'b1));
    runInst("R7 non-linkable target", 64'hA000, 32'h88, 0, 16'h0800);
    wrReg(1'b0, 4'd11, mkCtrl(4'b0011, 4'd0, 4'b0000, 1'b0));
    runInst("R7 disabled target", 64'hA000, 32'h88, 0, 16'h0000);
    wrReg(1'b1, 4'd12, 64'hA000); wrReg(1'b0, 4'd12, mkCtrl(4'b0000, 4'd0, 4'b1111, 1'b1));
    wrReg(1'b0, 4'd10, mkCtrl(4'b0001, 4'd12, 4'b1111, 1'b1));
    runInst("R7 address target", 64'hA000, 32'h88, 0, 16'h1000);
    wrReg(1'b0, 4'd9, mkCtrl(4'b0001, 4'd8, 4'b1111, 1'b0));
    runInst("R1 linked disabled", 64'h9000, 32'h77, 0, 16'h0000);
  endtask

  task automatic tBadType();
    clearAll();
    wrReg(1'b1, 4'd13, 64'h0000_0000_0000_0099);
    wrReg(1'b0, 4'd13, mkCtrl(4'b0100, 4'd0, 4'b1111, 1'b1));
    runInst("R8 code 0100", 64'h99, 32'h99, 0, 16'h0000);
    wrReg(1'b0, 4'd13, mkCtrl(4'b1100, 4'd0, 4'b1111, 1'b1));
    runInst("R8 code 1100", 64'h99, 32'h99, 0, 16'h0000);
    wrReg(1'b0, 4'd13, mkCtrl(4'b1110, 4'd0, 4'b1111, 1'b1));
    runInst("R8 code 1110", 64'h99, 32'h99, 0, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tReserved();
    tAddr();
    tTiming();
    tContext();
    tLink();
    tBadType();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++;
        nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule